// File: doc/BRIEF.md
# MAC Pause Flow Controller

This block handles symmetric link-level flow control for an Ethernet MAC. On the transmit side it compares the receive-FIFO fill level against a high-water mark. When the level climbs through that mark it asks the frame builder to send one pause frame, and that frame carries the configured pause time. Once the level falls below a lower mark, set by the high-water mark minus a hysteresis, it asks for one pause frame with time zero, which resumes the link partner.

On the receive side the frame parser hands it decoded pause frames as a strobe with a 16-bit quanta value. A counter loads that value and counts down once per quantum tick. While the counter is non-zero the block holds off the transmit queue. The hold is only raised between frames, so a frame already on the wire finishes. It is dropped as soon as the counter is empty.

A single 32-bit configuration word drives the block. Bit 0 lets received pause frames throttle transmission. Bit 2 lets the fill-level threshold generate pause frames. Bits [31:16] hold the outgoing pause time. The integrating register is expected to reset this field to 16 quanta.

Top module: `pause_flow_ctrl`

## Requirements
- R1: Configuration bits are decoded by position: bit 0 is the receive-honour enable, bit 2 is the threshold-send enable, and bits [31:16] are the pause time. All other bits, bit 1 included, have no effect.
- R2: With bit 2 set, a clock edge at which the fill level is at or above THRESH and the block was below the mark produces `tx_pause_req_o` for exactly one cycle after that edge. During that cycle `tx_pause_time_o` equals cfg bits [31:16].
- R3: While the fill level stays at or above the lower mark after an upward crossing, no further request is issued.
- R4: When the fill level drops below THRESH-HYST after an upward crossing, one request is issued with `tx_pause_time_o` = 0. Levels between the two marks issue nothing.
- R5: With bit 2 clear, `tx_pause_req_o` never asserts.
- R6: With bit 0 set, a received pause with quanta N>0 raises `tx_hold_o` two cycles after the strobe when no frame is active. The hold drops one cycle after the N-th quantum tick.
- R7: A received pause reloads the counter with its new quanta, whatever the count remaining.
- R8: A received pause with quanta 0 clears the counter, and `tx_hold_o` falls on the following cycle.
- R9: `tx_hold_o` only rises on an edge where `tx_frame_active_i` is low. A pending hold waits for the frame to end, and an active frame does not drop a raised hold.
- R10: With bit 0 clear, received pauses are ignored. Clearing bit 0 empties the counter and drops the hold one cycle later.
- R11: After reset, `tx_pause_req_o`, `tx_pause_time_o` and `tx_hold_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Flow-control configuration word |
| fill_level_i | input | FILL_W | Receive-FIFO fill level |
| rx_pause_valid_i | input | 1 | Decoded pause frame received |
| rx_pause_quanta_i | input | 16 | Pause time of the received frame |
| quanta_tick_i | input | 1 | One pulse per 512 bit times |
| tx_frame_active_i | input | 1 | A frame is being transmitted |
| tx_pause_req_o | output | 1 | Request to send a pause frame |
| tx_pause_time_o | output | 16 | Pause time for the requested frame |
| tx_hold_o | output | 1 | Hold off the transmit queue |

## Verification
The assertions check several properties on every cycle. Every non-zero request carries the pause time configured one cycle before it, and no request appears when the send enable was clear. Two non-zero requests never come back to back. The hold never rises right after an active-frame cycle, a zero-quanta pause is followed by release, and a disabled receive enable forces the hold low. Some behaviours only the bench scenarios can show: the exact count of quanta before release, reload mid-count, the hysteresis band producing no traffic, and a hold deferred until a frame ends.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int unsigned CFG_RX_EN_BIT = 0;
  localparam int unsigned CFG_TX_EN_BIT = 2;
  localparam int unsigned CFG_TIME_LSB  = 16;
  localparam int unsigned QUANTA_W      = 16;

  typedef logic [QUANTA_W-1:0] quanta_t;

  function automatic quanta_t cfg_time(input logic [31:0] cfg);
    return cfg[CFG_TIME_LSB +: QUANTA_W];
  endfunction
endpackage

// File: rtl/pause_xmit_trigger.sv
module pause_xmit_trigger
  import pause_pkg::*;
#(
  parameter int unsigned FILL_W = 10,
  parameter int unsigned THRESH = 768,
  parameter int unsigned HYST   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  quanta_t           xoff_time_i,
  output logic              req_o,
  output quanta_t           time_o
);
  localparam logic [FILL_W-1:0] HI_LVL = FILL_W'(THRESH);
  localparam logic [FILL_W-1:0] LO_LVL = FILL_W'(THRESH - HYST);

  logic    above_q, req_q;
  quanta_t time_q;
  logic    rise, fall;

  always_comb begin
    rise = !above_q && (fill_i >= HI_LVL);
    fall = above_q && (fill_i < LO_LVL);
  end

  // crossing state tracked regardless of enable; only the request is gated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      req_q   <= 1'b0;
      time_q  <= '0;
    end else begin
      if (rise)      above_q <= 1'b1;
      else if (fall) above_q <= 1'b0;
      req_q  <= en_i && (rise || fall);
      time_q <= (en_i && rise) ? xoff_time_i : '0;
    end
  end

  assign req_o  = req_q;
  assign time_o = time_q;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clear_i,
  input  logic    load_i,
  input  quanta_t load_val_i,
  input  logic    tick_i,
  output logic    busy_o
);
  quanta_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pause_hold_gate.sv
module pause_hold_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic frame_active_i,
  output logic hold_o
);
  logic hold_q;

  // assert only between frames; release at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= 1'b0;
    else if (!busy_i)         hold_q <= 1'b0;
    else if (!frame_active_i) hold_q <= 1'b1;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pause_pkg::*;
#(
  parameter int unsigned FILL_W = 10,
  parameter int unsigned THRESH = 768,
  parameter int unsigned HYST   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_i,
  input  logic [FILL_W-1:0] fill_level_i,
  input  logic              rx_pause_valid_i,
  input  logic [15:0]       rx_pause_quanta_i,
  input  logic              quanta_tick_i,
  input  logic              tx_frame_active_i,
  output logic              tx_pause_req_o,
  output logic [15:0]       tx_pause_time_o,
  output logic              tx_hold_o
);
  logic rx_en, tx_en, busy;
  logic unused_cfg;

  assign rx_en      = cfg_i[CFG_RX_EN_BIT];
  assign tx_en      = cfg_i[CFG_TX_EN_BIT];
  assign unused_cfg = ^{cfg_i[15:3], cfg_i[1]};

  pause_xmit_trigger #(
    .FILL_W(FILL_W), .THRESH(THRESH), .HYST(HYST)
  ) i_trigger (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en),
    .fill_i      (fill_level_i),
    .xoff_time_i (cfg_time(cfg_i)),
    .req_o       (tx_pause_req_o),
    .time_o      (tx_pause_time_o)
  );

  pause_quanta_timer i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!rx_en),
    .load_i     (rx_pause_valid_i && rx_en),
    .load_val_i (rx_pause_quanta_i),
    .tick_i     (quanta_tick_i),
    .busy_o     (busy)
  );

  pause_hold_gate i_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .busy_i         (busy),
    .frame_active_i (tx_frame_active_i),
    .hold_o         (tx_hold_o)
  );
endmodule

// File: rtl/pause_flow_ctrl_sva.sv
module pause_flow_ctrl_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_en_i,
  input logic        tx_en_i,
  input logic [15:0] cfg_time_i,
  input logic        rx_pause_valid_i,
  input logic [15:0] rx_pause_quanta_i,
  input logic        tx_frame_active_i,
  input logic        tx_pause_req_o,
  input logic [15:0] tx_pause_time_o,
  input logic        tx_hold_o
);
  p_xoff_time_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pause_req_o && tx_pause_time_o != 16'd0) |-> tx_pause_time_o == $past(cfg_time_i));

  p_no_req_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tx_en_i) |-> !tx_pause_req_o);

  p_single_xoff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pause_req_o && tx_pause_time_o != 16'd0) |=> !(tx_pause_req_o && tx_pause_time_o != 16'd0));

  p_zero_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pause_valid_i && rx_pause_quanta_i == 16'd0 && rx_en_i) |-> ##2 !tx_hold_o);

  p_hold_between_frames_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_o) |-> $past(!tx_frame_active_i));

  p_rx_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rx_en_i) && $past(!rx_en_i, 2)) |-> !tx_hold_o);
endmodule

bind pause_flow_ctrl pause_flow_ctrl_sva i_pause_flow_ctrl_sva (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .rx_en_i           (cfg_i[0]),
  .tx_en_i           (cfg_i[2]),
  .cfg_time_i        (cfg_i[31:16]),
  .rx_pause_valid_i  (rx_pause_valid_i),
  .rx_pause_quanta_i (rx_pause_quanta_i),
  .tx_frame_active_i (tx_frame_active_i),
  .tx_pause_req_o    (tx_pause_req_o),
  .tx_pause_time_o   (tx_pause_time_o),
  .tx_hold_o         (tx_hold_o)
);

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;
  localparam int FILL_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [31:0]       cfg = 32'h0010_0005;
  logic [FILL_W-1:0] fill = '0;
  logic              rx_v = 1'b0;
  logic [15:0]       rx_q = '0;
  logic              tick = 1'b0;
  logic              frame = 1'b0;
  logic              req;
  logic [15:0]       ptime;
  logic              hold;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  pause_flow_ctrl i_pause_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_i(cfg), .fill_level_i(fill),
    .rx_pause_valid_i(rx_v), .rx_pause_quanta_i(rx_q), .quanta_tick_i(tick),
    .tx_frame_active_i(frame), .tx_pause_req_o(req), .tx_pause_time_o(ptime),
    .tx_hold_o(hold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic rx_pause(input logic [15:0] q);
    rx_v = 1'b1; rx_q = q; cyc(); rx_v = 1'b0;
  endtask

  // scoreboard monitor: every request must match the next expected time
  always @(negedge clk) begin
    if (rst_ni && req && !done) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected request", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(ptime == e, "R2/R4 request time", ptime, e);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc();
    // R11 reset state
    chk(req == 0 && ptime == 0 && hold == 0, "R11 reset outputs", {req, hold}, 0);

    // R2 upward crossing, default time 16
    exp_q.push_back(16'd16);
    fill = 10'd800; cyc();
    chk(req == 1, "R2 request after crossing", req, 1);
    cyc();
    chk(req == 0, "R3 single pulse", req, 0);
    fill = 10'd900; cyc(2);
    chk(req == 0, "R3 no repeat while above", req, 0);
    // R4 hysteresis band then release
    fill = 10'd600; cyc(2);
    chk(req == 0, "R4 band silent", req, 0);
    exp_q.push_back(16'd0);
    fill = 10'd500; cyc();
    chk(req == 1 && ptime == 0, "R4 resume request", ptime, 0);
    cyc();

    // R1 pause time from bits [31:16]
    cfg = 32'h1234_0005;
    exp_q.push_back(16'h1234);
    fill = 10'd768; cyc();
    chk(req == 1 && ptime == 16'h1234, "R1 time field", ptime, 16'h1234);
    exp_q.push_back(16'd0);
    fill = 10'd100; cyc(2);

    // R5 send disabled; R1 bit 1 has no effect
    cfg = 32'h0010_0003;
    fill = 10'd800; cyc();
    chk(req == 0, "R5 no request when disabled", req, 0);
    cyc();
    fill = 10'd100; cyc();
    chk(req == 0, "R1 bit1 ignored", req, 0);
    cfg = 32'h0010_0005; cyc();

    // R6 hold for N quanta
    rx_pause(16'd3); cyc();
    chk(hold == 1, "R6 hold raised", hold, 1);
    pulse_tick(); pulse_tick();
    chk(hold == 1, "R6 hold after 2 of 3 ticks", hold, 1);
    pulse_tick(); cyc();
    chk(hold == 0, "R6 hold released after 3 ticks", hold, 0);

    // R7 reload
    rx_pause(16'd2); pulse_tick();
    rx_pause(16'd5);
    for (int i = 0; i < 4; i++) pulse_tick();
    cyc();
    chk(hold == 1, "R7 reload extends hold", hold, 1);
    pulse_tick(); cyc();
    chk(hold == 0, "R7 release after reload count", hold, 0);

    // R8 zero quanta releases
    rx_pause(16'd100); cyc();
    chk(hold == 1, "R8 hold before release", hold, 1);
    rx_pause(16'd0); cyc();
    chk(hold == 0, "R8 zero quanta release", hold, 0);

    // R9 frame in progress defers hold
    frame = 1'b1;
    rx_pause(16'd4); cyc(2);
    chk(hold == 0, "R9 hold deferred during frame", hold, 0);
    frame = 1'b0; cyc();
    chk(hold == 1, "R9 hold after frame end", hold, 1);
    frame = 1'b1; cyc();
    chk(hold == 1, "R9 frame does not drop hold", hold, 1);
    frame = 1'b0;
    rx_pause(16'd0); cyc();

    // R10 receive enable
    cfg = 32'h0010_0004; cyc();
    rx_pause(16'd5); cyc(2);
    chk(hold == 0, "R10 pause ignored when disabled", hold, 0);
    cfg = 32'h0010_0005;
    rx_pause(16'd5); cyc();
    chk(hold == 1, "R10 hold with enable", hold, 1);
    cfg = 32'h0010_0004; cyc(2);
    chk(hold == 0, "R10 disable releases hold", hold, 0);

    cyc(2);
    chk(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 0);
    finish_run();
  end
endmodule